// File: doc/BRIEF.md
# Scanline Ring Controller

This block keeps a ring of eight line descriptors that sit between a line producer and a word-stream consumer. The producer uses one command channel. It claims the descriptor at the head of the ring, writes the payload words for that line into an internal buffer, and then submits the descriptor with a word count and a replay count. There are also two shortcut commands. One builds a "skip n lines" descriptor. The other builds a "start of frame" descriptor that waits out the vertical back porch. Neither shortcut touches the payload buffer.

The consumer side takes descriptors in ring order from the tail. For each line it drives a word stream over a valid/ready handshake. The line is a sync command word, then the payload words, then a zero word that blanks the beam. A line can be replayed a set number of times before its slot is released. Each slot carries three flags: occupied, submitted and launched. These flags decide when streaming may begin and when the slot may be claimed again.

The streaming engine is a four-state machine:
- **IDLE** waits for a launchable tail slot. Transition *launch*: IDLE to SYNC.
- **SYNC** presents the sync word. Transition *to-body* goes to BODY when the word count is nonzero. Transition *empty-line* goes to TERM when the word count is zero.
- **BODY** presents the payload words in order. Transition *last-word* goes to TERM.
- **TERM** presents the zero word. Transition *replay* goes to SYNC while replays remain. Transition *release* goes to IDLE when none remain.

Top module: `scanring_ctrl`

## Requirements
- R1: The ring has 8 slots. `head_slot` shows the slot the next claim will take. Every claim-type command advances the head by one, wrapping from 7 to 0. The tail advances in the same circular order.
- R2: A plain claim (`cmd_op`=0) marks the head slot as occupied only, with submitted and launched clear. It sets the word count and replay count to 0 and sets the sync word to the horizontal-wait command 32'h0001_0000.
- R3: Plain claim, skip with n>0 (`cmd_op`=2) and frame (`cmd_op`=3) hold `cmd_ready` low while the head slot is occupied. Submit (`cmd_op`=1) and skip with n=0 are always ready.
- R4: Submit marks `cmd_slot` as submitted and loads its word count (`cmd_len`) and replay count (`cmd_rep`). `out_valid` stays low unless the tail slot is occupied and submitted. A slot is launched at most once per claim.
- R5: A line is len+2 words: the sync word, payload words 0..len-1 in index order, then 32'h0. While `out_valid` is high and `out_ready` is low, `out_data` holds.
- R6: When a line's zero word is accepted and the replay count is nonzero, the count drops by one and the same slot streams again from its sync word.
- R7: When a line's zero word is accepted with a replay count of zero, the slot is no longer occupied and the tail advances. The next slot launches without any producer action.
- R8: Skip (`cmd_op`=2) with n=`cmd_len`>0 claims and submits one slot in a single command. Its line is the horizontal-wait sync word, n-1 further horizontal-wait words, then zero. Skip with n=0 is accepted and changes nothing.
- R9: Frame (`cmd_op`=3) claims and submits one slot in a single command. Its sync word is the vertical-wait command 32'h0002_0000, followed by 33 horizontal-wait words, then zero.
- R10: `line_done` is a one-cycle pulse in the cycle after each line's zero word is accepted.
- R11: A submit in the same cycle that another line completes is applied without loss, and no slot is ever launched twice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 2 | 0 claim, 1 submit, 2 skip, 3 frame |
| cmd_slot | input | 3 | Target slot for submit |
| cmd_len | input | 7 | Word count for submit, or line count n for skip |
| cmd_rep | input | 8 | Replay count for submit |
| cmd_ready | output | 1 | Command accepted this cycle when high with cmd_valid |
| head_slot | output | 3 | Slot the next claim takes |
| wr_en | input | 1 | Payload write strobe |
| wr_slot | input | 3 | Payload write slot |
| wr_idx | input | 6 | Payload word index |
| wr_data | input | 32 | Payload word |
| out_valid | output | 1 | Stream word valid |
| out_data | output | 32 | Stream word |
| out_ready | input | 1 | Consumer accepts the word |
| line_done | output | 1 | Line finished pulse |

## Verification
The assertions rely on three promises from the producer:
- It submits only slots it has claimed.
- It never writes the payload of a slot that is launched and still occupied.
- It keeps word counts within 64, so skip n is at most 65.

The stimulus keeps these promises by design. The bench submits only slot numbers returned by its own claims. It writes payload only between a claim and the matching submit. All lengths are small constants.

The output stability check assumes nothing about `out_ready`. The bench therefore drives `out_ready` held high, pseudo-randomly toggled, and held low for long stretches, so that the ring fills and claims stall.

// File: rtl/scanring_pkg.sv
package scanring_pkg;
    typedef enum logic [1:0] {
        OP_CLAIM  = 2'd0,
        OP_SUBMIT = 2'd1,
        OP_SKIP   = 2'd2,
        OP_FRAME  = 2'd3
    } ring_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SYNC = 2'd1,
        ST_BODY = 2'd2,
        ST_TERM = 2'd3
    } line_state_e;
endpackage

// File: rtl/scanring_mem.sv
module scanring_mem #(
    parameter int SLOTS     = 8,
    parameter int MAX_WORDS = 64,
    parameter int W         = 32,
    localparam int PTR_W    = $clog2(SLOTS),
    localparam int IDX_W    = $clog2(MAX_WORDS)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_slot,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [W-1:0]     wr_data,
    input  logic [PTR_W-1:0] rd_slot,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [W-1:0]     rd_data
);
    logic [W-1:0] bank_rd [SLOTS];

    for (genvar g = 0; g < SLOTS; g++) begin : g_bank
        logic [W-1:0] words [MAX_WORDS];
        always_ff @(posedge clk) begin
            if (wr_en && (wr_slot == PTR_W'(g))) begin
                words[wr_idx] <= wr_data;
            end
        end
        assign bank_rd[g] = words[rd_idx];
    end

    assign rd_data = bank_rd[rd_slot];
endmodule

// File: rtl/scanring_slots.sv
module scanring_slots
    import scanring_pkg::*;
#(
    parameter int SLOTS    = 8,
    parameter int LEN_W    = 7,
    parameter int REP_W    = 8,
    parameter int BP_LINES = 33,
    localparam int PTR_W   = $clog2(SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  ring_op_e         cmd_op,
    input  logic [PTR_W-1:0] cmd_slot,
    input  logic [LEN_W-1:0] cmd_len,
    input  logic [REP_W-1:0] cmd_rep,
    output logic             cmd_ready,
    output logic [PTR_W-1:0] head_slot,
    output logic [PTR_W-1:0] tail_slot,
    output logic             tail_startable,
    output logic [LEN_W-1:0] tail_len,
    output logic [REP_W-1:0] tail_rep,
    output logic             tail_fill,
    output logic             tail_vsync,
    input  logic             start_evt,
    input  logic             replay_evt,
    input  logic             finish_evt
);
    logic [SLOTS-1:0] busy_q, ready_q, started_q, fill_q, vsync_q;
    logic [LEN_W-1:0] len_q [SLOTS];
    logic [REP_W-1:0] rep_q [SLOTS];
    logic [PTR_W-1:0] head_q, tail_q;
    logic             claim_kind, fire;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(SLOTS - 1)) ? '0 : p + 1'b1;
    endfunction

    assign claim_kind = (cmd_op == OP_CLAIM) || (cmd_op == OP_FRAME) ||
                        ((cmd_op == OP_SKIP) && (cmd_len != '0));
    assign cmd_ready  = claim_kind ? !busy_q[head_q] : 1'b1;
    assign fire       = cmd_valid && cmd_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q    <= '0;
            ready_q   <= '0;
            started_q <= '0;
            fill_q    <= '0;
            vsync_q   <= '0;
            head_q    <= '0;
            tail_q    <= '0;
            for (int i = 0; i < SLOTS; i++) begin
                len_q[i] <= '0;
                rep_q[i] <= '0;
            end
        end else begin
            if (fire) begin
                unique case (cmd_op)
                    OP_CLAIM: begin
                        busy_q[head_q]    <= 1'b1;
                        ready_q[head_q]   <= 1'b0;
                        started_q[head_q] <= 1'b0;
                        fill_q[head_q]    <= 1'b0;
                        vsync_q[head_q]   <= 1'b0;
                        len_q[head_q]     <= '0;
                        rep_q[head_q]     <= '0;
                        head_q            <= step(head_q);
                    end
                    OP_SUBMIT: begin
                        ready_q[cmd_slot] <= 1'b1;
                        len_q[cmd_slot]   <= cmd_len;
                        rep_q[cmd_slot]   <= cmd_rep;
                    end
                    OP_SKIP: begin
                        if (cmd_len != '0) begin
                            busy_q[head_q]    <= 1'b1;
                            ready_q[head_q]   <= 1'b1;
                            started_q[head_q] <= 1'b0;
                            fill_q[head_q]    <= 1'b1;
                            vsync_q[head_q]   <= 1'b0;
                            len_q[head_q]     <= cmd_len - 1'b1;
                            rep_q[head_q]     <= '0;
                            head_q            <= step(head_q);
                        end
                    end
                    OP_FRAME: begin
                        busy_q[head_q]    <= 1'b1;
                        ready_q[head_q]   <= 1'b1;
                        started_q[head_q] <= 1'b0;
                        fill_q[head_q]    <= 1'b1;
                        vsync_q[head_q]   <= 1'b1;
                        len_q[head_q]     <= LEN_W'(BP_LINES);
                        rep_q[head_q]     <= '0;
                        head_q            <= step(head_q);
                    end
                endcase
            end
            if (start_evt)  started_q[tail_q] <= 1'b1;
            if (replay_evt) rep_q[tail_q]     <= rep_q[tail_q] - 1'b1;
            if (finish_evt) begin
                busy_q[tail_q] <= 1'b0;
                tail_q         <= step(tail_q);
            end
        end
    end

    assign head_slot      = head_q;
    assign tail_slot      = tail_q;
    assign tail_startable = busy_q[tail_q] && ready_q[tail_q] && !started_q[tail_q];
    assign tail_len       = len_q[tail_q];
    assign tail_rep       = rep_q[tail_q];
    assign tail_fill      = fill_q[tail_q];
    assign tail_vsync     = vsync_q[tail_q];

    AST_HEAD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && cmd_op == OP_CLAIM) |=> (head_q == step($past(head_q)))); // R1
    AST_CLAIM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && cmd_op == OP_CLAIM) |=> (busy_q[$past(head_q)] && !ready_q[$past(head_q)] &&
                                          len_q[$past(head_q)] == '0 && rep_q[$past(head_q)] == '0)); // R2
    AST_NO_DOUBLE_START: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |-> (!started_q[tail_q] && ready_q[tail_q])); // R11
    AST_FINISH_LAUNCHED: assert property (@(posedge clk) disable iff (!rst_n)
        finish_evt |-> (started_q[tail_q] && busy_q[tail_q] && rep_q[tail_q] == '0)); // R7
    AST_REPLAY_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        replay_evt |=> (rep_q[$past(tail_q)] == $past(rep_q[tail_q]) - 1'b1)); // R6
endmodule

// File: rtl/scanring_stream.sv
module scanring_stream
    import scanring_pkg::*;
#(
    parameter int W             = 32,
    parameter int LEN_W         = 7,
    parameter int REP_W         = 8,
    parameter int IDX_W         = 6,
    parameter logic [W-1:0] CMD_HSYNC = 32'h0001_0000,
    parameter logic [W-1:0] CMD_VSYNC = 32'h0002_0000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tail_startable,
    input  logic [LEN_W-1:0] tail_len,
    input  logic [REP_W-1:0] tail_rep,
    input  logic             tail_fill,
    input  logic             tail_vsync,
    output logic [IDX_W-1:0] rd_idx,
    input  logic [W-1:0]     rd_data,
    output logic             out_valid,
    output logic [W-1:0]     out_data,
    input  logic             out_ready,
    output logic             start_evt,
    output logic             replay_evt,
    output logic             finish_evt,
    output logic             line_done
);
    line_state_e      state_q, state_nx;
    logic [LEN_W-1:0] idx_q, idx_nx, idx_inc;
    logic             done_q;

    assign idx_inc = idx_q + 1'b1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_nx;
            idx_q   <= idx_nx;
            done_q  <= (state_q == ST_TERM) && out_ready;
        end
    end

    always_comb begin
        state_nx = state_q;
        idx_nx   = idx_q;
        unique case (state_q)
            ST_IDLE: if (tail_startable) state_nx = ST_SYNC;
            ST_SYNC: if (out_ready) begin
                idx_nx   = '0;
                state_nx = (tail_len == '0) ? ST_TERM : ST_BODY;
            end
            ST_BODY: if (out_ready) begin
                idx_nx = idx_inc;
                if (idx_inc == tail_len) state_nx = ST_TERM;
            end
            ST_TERM: if (out_ready) state_nx = (tail_rep != '0) ? ST_SYNC : ST_IDLE;
        endcase
    end

    always_comb begin
        out_valid  = 1'b0;
        out_data   = '0;
        start_evt  = 1'b0;
        replay_evt = 1'b0;
        finish_evt = 1'b0;
        unique case (state_q)
            ST_IDLE: start_evt = tail_startable;
            ST_SYNC: begin
                out_valid = 1'b1;
                out_data  = tail_vsync ? CMD_VSYNC : CMD_HSYNC;
            end
            ST_BODY: begin
                out_valid = 1'b1;
                out_data  = tail_fill ? CMD_HSYNC : rd_data;
            end
            ST_TERM: begin
                out_valid  = 1'b1;
                out_data   = '0;
                replay_evt = out_ready && (tail_rep != '0);
                finish_evt = out_ready && (tail_rep == '0);
            end
        endcase
    end

    assign rd_idx    = idx_q[IDX_W-1:0];
    assign line_done = done_q;

    AST_HOLD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R5
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        line_done |=> !line_done); // R10
    AST_LAUNCH_ONLY_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !tail_startable) |=> !out_valid); // R4
endmodule

// File: rtl/scanring_ctrl.sv
module scanring_ctrl
    import scanring_pkg::*;
#(
    parameter int SLOTS     = 8,
    parameter int MAX_WORDS = 64,
    parameter int W         = 32,
    parameter int REP_W     = 8,
    parameter int BP_LINES  = 33,
    parameter logic [W-1:0] CMD_HSYNC = 32'h0001_0000,
    parameter logic [W-1:0] CMD_VSYNC = 32'h0002_0000,
    localparam int PTR_W    = $clog2(SLOTS),
    localparam int IDX_W    = $clog2(MAX_WORDS),
    localparam int LEN_W    = $clog2(MAX_WORDS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [PTR_W-1:0] cmd_slot,
    input  logic [LEN_W-1:0] cmd_len,
    input  logic [REP_W-1:0] cmd_rep,
    output logic             cmd_ready,
    output logic [PTR_W-1:0] head_slot,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_slot,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [W-1:0]     wr_data,
    output logic             out_valid,
    output logic [W-1:0]     out_data,
    input  logic             out_ready,
    output logic             line_done
);
    logic [PTR_W-1:0] tail_slot;
    logic             tail_startable, tail_fill, tail_vsync;
    logic [LEN_W-1:0] tail_len;
    logic [REP_W-1:0] tail_rep;
    logic [IDX_W-1:0] rd_idx;
    logic [W-1:0]     rd_data;
    logic             start_evt, replay_evt, finish_evt;

    scanring_slots #(
        .SLOTS(SLOTS), .LEN_W(LEN_W), .REP_W(REP_W), .BP_LINES(BP_LINES)
    ) u_slots (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_op(ring_op_e'(cmd_op)), .cmd_slot(cmd_slot),
        .cmd_len(cmd_len), .cmd_rep(cmd_rep), .cmd_ready(cmd_ready),
        .head_slot(head_slot), .tail_slot(tail_slot),
        .tail_startable(tail_startable), .tail_len(tail_len), .tail_rep(tail_rep),
        .tail_fill(tail_fill), .tail_vsync(tail_vsync),
        .start_evt(start_evt), .replay_evt(replay_evt), .finish_evt(finish_evt)
    );

    scanring_mem #(
        .SLOTS(SLOTS), .MAX_WORDS(MAX_WORDS), .W(W)
    ) u_mem (
        .clk(clk), .wr_en(wr_en), .wr_slot(wr_slot), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_slot(tail_slot), .rd_idx(rd_idx), .rd_data(rd_data)
    );

    scanring_stream #(
        .W(W), .LEN_W(LEN_W), .REP_W(REP_W), .IDX_W(IDX_W),
        .CMD_HSYNC(CMD_HSYNC), .CMD_VSYNC(CMD_VSYNC)
    ) u_stream (
        .clk(clk), .rst_n(rst_n),
        .tail_startable(tail_startable), .tail_len(tail_len), .tail_rep(tail_rep),
        .tail_fill(tail_fill), .tail_vsync(tail_vsync),
        .rd_idx(rd_idx), .rd_data(rd_data),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
        .start_evt(start_evt), .replay_evt(replay_evt), .finish_evt(finish_evt),
        .line_done(line_done)
    );
endmodule

// File: tb/scanring_ctrl_test.sv
module scanring_ctrl_test;
    localparam logic [31:0] HS = 32'h0001_0000;
    localparam logic [31:0] VS = 32'h0002_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic [2:0]  cmd_slot = 3'd0;
    logic [6:0]  cmd_len = 7'd0;
    logic [7:0]  cmd_rep = 8'd0;
    logic        cmd_ready;
    logic [2:0]  head_slot;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_slot = 3'd0;
    logic [5:0]  wr_idx = 6'd0;
    logic [31:0] wr_data = 32'd0;
    logic        out_valid;
    logic [31:0] out_data;
    logic        out_ready = 1'b0;
    logic        line_done;

    always #10 clk = ~clk;

    scanring_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_slot(cmd_slot), .cmd_len(cmd_len), .cmd_rep(cmd_rep), .cmd_ready(cmd_ready),
        .head_slot(head_slot), .wr_en(wr_en), .wr_slot(wr_slot), .wr_idx(wr_idx),
        .wr_data(wr_data), .out_valid(out_valid), .out_data(out_data),
        .out_ready(out_ready), .line_done(line_done)
    );

    int checks = 0, fails = 0, stall_seen = 0, line_cnt = 0, rdy_mode = 0;
    bit finished = 0;

    // behavioural reference model
    bit          m_busy [8];
    bit          m_ready [8];
    bit          m_fill [8];
    bit          m_vs [8];
    int          m_len [8];
    int          m_rep [8];
    logic [31:0] m_pay [8][64];
    int          m_head = 0, m_tail = 0, m_pos = 0;
    bit          m_done_due = 0;

    function automatic void chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endfunction

    function automatic logic [31:0] exp_word(input int s, input int p);
        if (p == 0) return m_vs[s] ? VS : HS;
        if (p <= m_len[s]) return m_fill[s] ? HS : m_pay[s][p-1];
        return 32'h0;
    endfunction

    function automatic bit any_busy();
        for (int i = 0; i < 8; i++) if (m_busy[i]) return 1'b1;
        return 1'b0;
    endfunction

    function automatic void m_take(input int len, input bit rdy, input bit fill, input bit vs);
        m_busy[m_head] = 1; m_ready[m_head] = rdy; m_fill[m_head] = fill;
        m_vs[m_head] = vs; m_len[m_head] = len; m_rep[m_head] = 0;
        m_head = (m_head + 1) % 8;
    endfunction

    always @(negedge clk) begin
        if (rst_n) begin
            chk(head_slot == 3'(m_head), "R1 head pointer", 32'(head_slot), 32'(m_head));
            chk(line_done == m_done_due, "R10 line_done timing", 32'(line_done), 32'(m_done_due));
            if (line_done) line_cnt++;
            m_done_due = 0;
            if (!(m_busy[m_tail] && m_ready[m_tail]))
                chk(out_valid == 1'b0, "R4 no stream before submit", 32'(out_valid), 32'd0);
            if (cmd_valid) begin
                bit need;
                need = (cmd_op == 2'd0) || (cmd_op == 2'd3) || (cmd_op == 2'd2 && cmd_len != 0);
                chk(cmd_ready == (need ? !m_busy[m_head] : 1'b1), "R3 claim stall",
                    32'(cmd_ready), 32'(need ? !m_busy[m_head] : 1'b1));
                if (!cmd_ready) stall_seen++;
            end
            if (out_valid && out_ready) begin
                logic [31:0] e;
                string tag;
                e = exp_word(m_tail, m_pos);
                tag = m_vs[m_tail] ? "R9 frame word" : (m_fill[m_tail] ? "R8 skip word" : "R5 line word");
                chk(out_data == e, tag, out_data, e);
                if (m_pos == m_len[m_tail] + 1) begin
                    m_done_due = 1;
                    m_pos = 0;
                    if (m_rep[m_tail] > 0) m_rep[m_tail]--;          // R6
                    else begin m_busy[m_tail] = 0; m_tail = (m_tail + 1) % 8; end  // R7
                end else m_pos++;
            end
            if (cmd_valid && cmd_ready) begin
                unique case (cmd_op)
                    2'd0: m_take(0, 0, 0, 0);
                    2'd1: begin
                        m_ready[cmd_slot] = 1; m_len[cmd_slot] = int'(cmd_len); m_rep[cmd_slot] = int'(cmd_rep);
                    end
                    2'd2: if (cmd_len != 0) m_take(int'(cmd_len) - 1, 1, 1, 0);
                    2'd3: m_take(33, 1, 1, 1);
                endcase
            end
            if (wr_en) m_pay[wr_slot][wr_idx] = wr_data;
        end
    end

    initial begin
        forever begin
            @(posedge clk); #2;
            if (rdy_mode == 0) out_ready = 1'b1;
            else if (rdy_mode == 1) out_ready = 1'($urandom_range(0, 1));
            else out_ready = 1'b0;
        end
    end

    task automatic issue(input int op, input int slot, input int len, input int rep, output int got);
        @(posedge clk); #2;
        cmd_valid = 1'b1; cmd_op = 2'(op); cmd_slot = 3'(slot); cmd_len = 7'(len); cmd_rep = 8'(rep);
        forever begin
            @(negedge clk);
            if (cmd_ready) break;
        end
        got = int'(head_slot);
        @(posedge clk); #2;
        cmd_valid = 1'b0;
    endtask

    task automatic put(input int slot, input int idx, input logic [31:0] d);
        @(posedge clk); #2;
        wr_en = 1'b1; wr_slot = 3'(slot); wr_idx = 6'(idx); wr_data = d;
        @(posedge clk); #2;
        wr_en = 1'b0;
    endtask

    task automatic drain();
        forever begin
            @(negedge clk);
            if (!any_busy()) break;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        int s, a, b, g, h0;
        for (int i = 0; i < 8; i++) begin
            m_busy[i] = 0; m_ready[i] = 0; m_fill[i] = 0; m_vs[i] = 0; m_len[i] = 0; m_rep[i] = 0;
        end
        repeat (3) @(posedge clk); #2;
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R4 reset out_valid", 32'(out_valid), 32'd0);
        chk(head_slot == 3'd0, "R1 reset head", 32'(head_slot), 32'd0);
        chk(cmd_ready == 1'b1, "R3 reset ready", 32'(cmd_ready), 32'd1);

        // R2 R5: plain data line
        issue(0, 0, 0, 0, s);
        put(s, 0, 32'hA000_0001); put(s, 1, 32'hA000_0002); put(s, 2, 32'hA000_0003);
        issue(1, s, 3, 0, g);
        drain();

        // R6: replayed line under random backpressure
        rdy_mode = 1;
        issue(0, 0, 0, 0, s);
        put(s, 0, 32'hB0B0_0010); put(s, 1, 32'hB0B0_0020);
        issue(1, s, 2, 2, g);
        drain();

        // R8: skip 0 does nothing, skip 1 and skip 4 build lines
        h0 = int'(head_slot);
        issue(2, 0, 0, 0, g);
        repeat (2) @(negedge clk);
        chk(head_slot == 3'(h0), "R8 skip zero ignored", 32'(head_slot), 32'(h0));
        chk(out_valid == 1'b0, "R8 skip zero no output", 32'(out_valid), 32'd0);
        issue(2, 0, 1, 0, g);
        issue(2, 0, 4, 0, g);
        drain();

        // R9: frame preparation
        rdy_mode = 0;
        issue(3, 0, 0, 0, g);
        drain();

        // R5 R6: empty data line replayed once
        issue(0, 0, 0, 0, s);
        issue(1, s, 0, 1, g);
        drain();

        // R3 R1: fill the ring while the consumer stalls, then one more claim
        rdy_mode = 2;
        for (int i = 0; i < 8; i++) issue(2, 0, 2, 0, g);
        fork
            begin repeat (30) @(posedge clk); rdy_mode = 0; end
        join_none
        issue(2, 0, 3, 0, g);
        drain();
        chk(stall_seen > 0, "R3 stall observed", 32'(stall_seen), 32'd1);

        // R11: submit of one slot overlapping completion of the previous
        issue(0, 0, 0, 0, a);
        issue(0, 0, 0, 0, b);
        put(a, 0, 32'hC0DE_0001);
        issue(1, a, 1, 0, g);
        issue(1, b, 0, 0, g);
        drain();

        chk(line_cnt == 20, "R10 line count", 32'(line_cnt), 32'd20);
        chk(!any_busy(), "R7 all released", 32'(any_busy()), 32'd0);
        report();
    end
endmodule